// File: doc/BRIEF.md
# PCI Interrupt Router

This block takes interrupt events raised by devices on a PCI bus and steers them onto one CPU interrupt output. An event names the requesting slot (0 to 31) and the interrupt pin that the device used (0 to 3, for pins A to D). A fixed board-level swizzle turns the slot and pin into an internal line number. Lines are numbered from a base of 32, so the local line index is the line number minus 32.

Two 32-bit configuration words come from the register file: an edge-select word and a polarity word. Bit n of each word applies to local line n. When the selected line is edge-configured, the CPU output gives a single-cycle pulse. When it is level-configured, the output is driven to that line's polarity bit and holds there.

Slots that the board does not wire use the raw pin number as the line number. That number lies below the base, so such events leave the output untouched. Latching which line fired, and the CPU-side interrupt controller, belong to other blocks.

Top module: `pcirq_router`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cpu_irq` is 0.
- R2: An event from slot 5 with pin p selects local line p, for p = 0 to 3.
- R3: An event from slot 6 selects local line 4 for every pin. An event from slot 7 selects local line 5 for every pin.
- R4: An event from slot s in 8 to 12 with pin p selects local line (s - 8 + p) + 6, so the lines run from 6 to 13.
- R5: An event from any other slot keeps the raw pin value (0 to 3) as its line number. That number is below the base of 32, so the local index falls outside 0 to 31 and the event has no effect on `cpu_irq`.
- R6: When bit n of `edge_cfg` is 1 and an event selects local line n, `cpu_irq` is 1 for exactly one cycle and then returns to 0, unless another event arrives.
- R7: When bit n of `edge_cfg` is 0 and an event selects local line n, `cpu_irq` takes the value of bit n of `pol_cfg`.
- R8: `cpu_irq` changes in the clock cycle after the clock edge that samples `evt_valid` high. The route passes through exactly one register.
- R9: With no event and no pulse in progress, `cpu_irq` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An interrupt event is presented this cycle |
| evt_slot | input | 5 | Slot number of the requesting device |
| evt_pin | input | 2 | Interrupt pin index, 0 = A to 3 = D |
| edge_cfg | input | 32 | Per-line edge select; bit n set makes local line n pulse |
| pol_cfg | input | 32 | Per-line level value used when the line is level-configured |
| cpu_irq | output | 1 | Interrupt output to the CPU |

## Verification
Single-hot polarity words are swept while every slot from 4 to 13 is tried with every pin. Only the event that lands on the hot line raises the output, and any other line pulls it back down. This pins the swizzle of each slot group down to the exact line and separates the mapped slots from the unmapped ones. Alternating edge and polarity patterns, each followed by idle cycles, separate a one-cycle pulse from a held level. An unmapped event that arrives during a pulse shows that it changes nothing. Runs of idle cycles after a level has been set check that the output holds.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int SLOT_W    = 5;
  localparam int PIN_W     = 2;
  localparam int LINE_BASE = 32;
  localparam int ABS_W     = 8;

  // Board swizzle: slot + pin -> absolute line number (base-relative for wired slots)
  function automatic logic [ABS_W-1:0] route_line(input logic [SLOT_W-1:0] slot,
                                                  input logic [PIN_W-1:0]  pin);
    logic [ABS_W-1:0] s, p, base;
    s    = ABS_W'(slot);
    p    = ABS_W'(pin);
    base = ABS_W'(LINE_BASE);
    if (slot == SLOT_W'(5))
      route_line = base + (p & ABS_W'(3));
    else if (slot == SLOT_W'(6))
      route_line = base + ABS_W'(4);
    else if (slot == SLOT_W'(7))
      route_line = base + ABS_W'(5);
    else if (slot >= SLOT_W'(8) && slot <= SLOT_W'(12))
      route_line = base + (s - ABS_W'(8)) + p + ABS_W'(6);
    else
      route_line = p;
  endfunction
endpackage

// File: rtl/pcirq_swizzle.sv
module pcirq_swizzle
  import pcirq_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  output logic [ABS_W-1:0]  abs_line
);
  always_comb abs_line = route_line(slot, pin);
endmodule

// File: rtl/pcirq_line_select.sv
module pcirq_line_select
  import pcirq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [ABS_W-1:0]     abs_line,
  input  logic [NUM_LINES-1:0] edge_cfg,
  input  logic [NUM_LINES-1:0] pol_cfg,
  output logic                 hit,
  output logic                 is_edge,
  output logic                 pol_bit
);
  logic [ABS_W-1:0] rel;
  logic [IDX_W-1:0] idx;

  always_comb begin
    rel     = abs_line - ABS_W'(LINE_BASE);
    idx     = rel[IDX_W-1:0];
    hit     = (abs_line >= ABS_W'(LINE_BASE)) &&
              (abs_line <  ABS_W'(LINE_BASE + NUM_LINES));
    is_edge = hit & edge_cfg[idx];
    pol_bit = hit & pol_cfg[idx];
  end
endmodule

// File: rtl/pcirq_out_stage.sv
module pcirq_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid,
  input  logic hit,
  input  logic is_edge,
  input  logic pol_bit,
  output logic irq
);
  logic irq_q, pulse_q, take;

  assign take = evt_valid & hit;
  assign irq  = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (take) begin
      irq_q   <= is_edge ? 1'b1 : pol_bit;
      pulse_q <= is_edge;
    end else if (pulse_q) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  // R6
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_edge) |=> irq);
  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !take) |=> !irq);
  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_edge) |=> (irq == $past(pol_bit)));
  // R5
  no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !hit && !pulse_q) |=> $stable(irq));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !pulse_q) |=> $stable(irq));
endmodule

// File: rtl/pcirq_router.sv
module pcirq_router
  import pcirq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic [SLOT_W-1:0]    evt_slot,
  input  logic [PIN_W-1:0]     evt_pin,
  input  logic [NUM_LINES-1:0] edge_cfg,
  input  logic [NUM_LINES-1:0] pol_cfg,
  output logic                 cpu_irq
);
  logic [ABS_W-1:0] abs_line;
  logic             hit, is_edge, pol_bit;

  pcirq_swizzle u_swz (
    .slot     (evt_slot),
    .pin      (evt_pin),
    .abs_line (abs_line)
  );

  pcirq_line_select #(.NUM_LINES(NUM_LINES)) u_sel (
    .abs_line (abs_line),
    .edge_cfg (edge_cfg),
    .pol_cfg  (pol_cfg),
    .hit      (hit),
    .is_edge  (is_edge),
    .pol_bit  (pol_bit)
  );

  pcirq_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .hit       (hit),
    .is_edge   (is_edge),
    .pol_bit   (pol_bit),
    .irq       (cpu_irq)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !cpu_irq);
  // R3
  slot6_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot == SLOT_W'(6)) |-> (abs_line == ABS_W'(LINE_BASE + 4)));
  // R3
  slot7_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot == SLOT_W'(7)) |-> (abs_line == ABS_W'(LINE_BASE + 5)));
  // R5
  unwired_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot < SLOT_W'(5)) |-> !hit);
endmodule

// File: tb/pcirq_router_bench.sv
module pcirq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic        cpu_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit exp_irq = 0;
  bit exp_pulse = 0;

  always #10 clk = ~clk;

  pcirq_router u_pcirq_router (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_pin(evt_pin), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg), .cpu_irq(cpu_irq)
  );

  // Reference swizzle, written as a table of cases: -1 means no local line
  function automatic int ref_local(int slot, int pin);
    case (slot)
      5:               return pin;
      6:               return 4;
      7:               return 5;
      8, 9, 10, 11, 12: return slot + pin - 2;
      default:         return -1;
    endcase
  endfunction

  function automatic string tag_for(int slot, int pin);
    int loc = ref_local(slot, pin);
    if (loc < 0) return "R5";
    if (edge_cfg[loc]) return "R6 R8";
    if (slot == 5) return "R2 R7 R8";
    if (slot < 8) return "R3 R7";
    return "R4 R7";
  endfunction

  task automatic check(input string tag);
    checks++;
    if (cpu_irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: cpu_irq=%0b expected %0b (t=%0t)", tag, cpu_irq, exp_irq, $time);
    end
  endtask

  task automatic step(input bit v, input int slot, input int pin);
    string tag;
    int loc;
    evt_valid = v;
    evt_slot  = 5'(slot);
    evt_pin   = 2'(pin);
    tag = v ? tag_for(slot, pin) : (exp_pulse ? "R6" : "R9");
    loc = v ? ref_local(slot, pin) : -1;
    @(posedge clk);
    if (loc >= 0) begin
      if (edge_cfg[loc]) begin exp_irq = 1; exp_pulse = 1; end
      else begin exp_irq = pol_cfg[loc]; exp_pulse = 0; end
    end else if (exp_pulse) begin
      exp_irq = 0; exp_pulse = 0;
    end
    @(negedge clk);
    evt_valid = 1'b0;
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // Single-hot level sweep
    for (int k = 0; k < 14; k++) begin
      edge_cfg = '0;
      pol_cfg  = 32'(1) << k;
      for (int s = 4; s < 14; s++)
        for (int p = 0; p < 4; p++)
          step(1, s, p);
    end

    // Hold a level high, then idle (R9) and unwired events (R5)
    edge_cfg = '0; pol_cfg = 32'h0000_0010;
    step(1, 6, 2);
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    for (int s = 0; s < 5; s++) step(1, s, 3);
    step(1, 20, 1);
    step(1, 31, 0);

    // Edge patterns with idle gaps
    for (int pat = 0; pat < 2; pat++) begin
      edge_cfg = pat == 0 ? 32'h0000_2AAA : 32'h0000_1555;
      pol_cfg  = pat == 0 ? 32'h0000_1555 : 32'h0000_0000;
      for (int s = 4; s < 14; s++)
        for (int p = 0; p < 4; p++) begin
          step(1, s, p);
          step(0, 0, 0);
        end
    end

    // Unwired event during a pulse: pulse still ends (R6, R5)
    edge_cfg = 32'h0000_0020; pol_cfg = 32'h0;
    step(1, 7, 0);
    step(1, 2, 1);
    step(0, 0, 0);
    // Back-to-back edge events keep the output high
    step(1, 7, 3);
    step(1, 7, 1);
    step(0, 0, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule